// File: doc/BRIEF.md
# I2C Master Start and Address Engine

This block is a register-controlled two-wire bus controller reduced to the opening of a master transfer. Out of reset it sits as a slave receiver with its bus pins released. Software first checks that the bus is free. It then loads a byte made of a seven-bit slave address and a direction bit, and issues one control write that requests a start. The engine drives SCL and SDA as open-drain pull-downs. It produces the start condition, shifts the byte out MSB first on eight SCL clocks, releases SDA on a ninth clock and samples the acknowledge.

On the falling edge of the ninth clock the engine clears its pending flag, which raises the interrupt, and keeps SCL low until software sets the flag again. If the slave acknowledged, the transmit flag takes a new value from the direction bit: a read makes the controller a receiver and a write keeps it a transmitter. If the slave did not acknowledge, the transmit flag is left as it was, and a last-received-bit status flag shows the high level that was sampled. A bus-activity monitor watches synchronised copies of both lines. It marks the bus busy on any start condition and free on any stop condition, whoever drives the bus.

Top module: `i2c_addr_master`

## Requirements
- R1: After reset the control register (address 1) reads 0x10: master bit 7 = 0, transmit bit 6 = 0, busy bit 5 = 0, pending bit 4 = 1. The status register (address 2) reads 0x00, the divider register (address 3) reads 3, irq_o is 0 and both pull-downs are off.
- R2: A control write with bits 7..4 = 1111 is a start request. It is accepted only while the busy flag is 0 and the engine is idle. Otherwise the write is dropped entirely: the control register keeps its value and SCL does not move.
- R3: The buffer register (address 0) is written and read back while the engine is idle. Bits 7..1 hold the slave address and bit 0 holds the direction (1 = read).
- R4: An accepted start is followed by exactly nine SCL high pulses. On the first eight, SDA carries the buffer byte MSB first, valid while SCL is high.
- R5: The engine's SDA pull-down is off during the ninth SCL pulse.
- R6: At the falling edge of the ninth pulse the pending bit becomes 0. irq_o, which equals master AND NOT pending, becomes 1.
- R7: While master = 1 and pending = 0, SCL is held low. A control write with bit 4 = 1 sets pending, releases SCL and drops irq_o.
- R8: If SDA is low at the end of the ninth high phase, transmit becomes the inverse of the direction bit and status bit 0 becomes 0. If SDA is high, transmit keeps its value (1 after a start request) and status bit 0 becomes 1.
- R9: The SCL half period is D+1 clock cycles, where D is the divider value and D must be at least 2. SDA falls while SCL is high, after both lines have been released for one half period. SCL first falls D+1 cycles after that SDA fall, and each SCL high pulse lasts D+1 cycles.
- R10: The busy flag (control bit 5 and status bit 5) is set by any start condition (SDA falling while SCL high) and cleared by any stop condition (SDA rising while SCL high), whichever device drives the lines.
- R11: A control write that is not a start request, made while the engine is idle, loads master from bit 7 and transmit from bit 6. Writing 1 to bit 4 sets pending; writing 0 to bit 4 leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 buffer, 1 control, 2 status, 3 divider |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational from reg_addr) |
| irq_o | output | 1 | Interrupt request, master AND NOT pending |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe_o | output | 1 | 1 pulls SCL low |
| sda_oe_o | output | 1 | 1 pulls SDA low |

## Verification
The hardest case to reach from the ports is a start request that meets a busy bus. The controller itself stays idle, so the bench plays a second master: it pulls SDA low while SCL is released, which the monitor takes as a foreign start. The bench then issues the start request and checks that SCL stays quiet and that the control register is unchanged. A slave model in the bench counts SCL rising edges, so it can drive or withhold the acknowledge exactly on the ninth clock, and it ends each transfer with a stop condition so that the next byte of the sweep can start.

// File: rtl/i2c_am_pkg.sv
package i2c_am_pkg;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_SETUP,
        SQ_START,
        SQ_LOW,
        SQ_HIGH,
        SQ_HOLD
    } seq_state_e;

    localparam logic [1:0] RA_BUF  = 2'd0;
    localparam logic [1:0] RA_CTL  = 2'd1;
    localparam logic [1:0] RA_STAT = 2'd2;
    localparam logic [1:0] RA_DIV  = 2'd3;

    localparam int CTL_MST  = 7;
    localparam int CTL_TX   = 6;
    localparam int CTL_BSY  = 5;
    localparam int CTL_PEND = 4;
    localparam int STAT_BSY = 5;
    localparam int STAT_LRB = 0;

    localparam logic [3:0] START_CODE = 4'hF;

endpackage

// File: rtl/i2c_am_linemon.sv
module i2c_am_linemon #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s_o,
    output logic busy_o
);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] scl_sh;
        logic [SYNC_STAGES-1:0] sda_sh;
        logic                   scl_prev;
        logic                   sda_prev;
        logic                   busy;
    } lm_t;

    lm_t  q, d;
    logic scl_s, sda_s, start_ev, stop_ev;

    assign scl_s = q.scl_sh[SYNC_STAGES-1];
    assign sda_s = q.sda_sh[SYNC_STAGES-1];

    always_comb begin
        d           = q;
        d.scl_sh    = q.scl_sh << 1;
        d.scl_sh[0] = scl_i;
        d.sda_sh    = q.sda_sh << 1;
        d.sda_sh[0] = sda_i;
        d.scl_prev  = scl_s;
        d.sda_prev  = sda_s;
        start_ev    = scl_s && q.scl_prev && q.sda_prev && !sda_s;
        stop_ev     = scl_s && q.scl_prev && !q.sda_prev && sda_s;
        if (start_ev) begin
            d.busy = 1'b1;
        end else if (stop_ev) begin
            d.busy = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.scl_sh   <= '1;
            q.sda_sh   <= '1;
            q.scl_prev <= 1'b1;
            q.sda_prev <= 1'b1;
            q.busy     <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign sda_s_o = sda_s;
    assign busy_o  = q.busy;

endmodule

// File: rtl/i2c_am_halfclk.sv
module i2c_am_halfclk #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } hc_t;

    hc_t q, d;

    always_comb begin
        d = q;
        if (!run_i || q.cnt == div_i) begin
            d.cnt = '0;
        end else begin
            d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.cnt <= '0;
        end else begin
            q <= d;
        end
    end

    assign tick_o = run_i && (q.cnt == div_i);

    AST_HALF_PERIOD_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        run_i |-> q.cnt <= div_i); // R9

endmodule

// File: rtl/i2c_am_seq.sv
module i2c_am_seq
    import i2c_am_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go_i,
    input  logic [BYTE_W-1:0] byte_i,
    input  logic              pend_i,
    input  logic              tick_i,
    input  logic              sda_s_i,
    output logic              run_o,
    output logic              idle_o,
    output logic              done_o,
    output logic              ack_line_o,
    output logic              scl_oe_o,
    output logic              sda_oe_o
);

    localparam int CNT_W = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W);

    typedef struct packed {
        seq_state_e        st;
        logic [BYTE_W-1:0] sh;
        logic [CNT_W-1:0]  cnt;
    } sq_t;

    sq_t  q, d;
    logic done;

    always_comb begin
        d    = q;
        done = 1'b0;
        case (q.st)
            SQ_IDLE: begin
                if (go_i) begin
                    d.st  = SQ_SETUP;
                    d.sh  = byte_i;
                    d.cnt = '0;
                end
            end
            SQ_SETUP: if (tick_i) d.st = SQ_START;
            SQ_START: if (tick_i) d.st = SQ_LOW;
            SQ_LOW:   if (tick_i) d.st = SQ_HIGH;
            SQ_HIGH: begin
                if (tick_i) begin
                    if (q.cnt == LAST) begin
                        d.st = SQ_HOLD;
                        done = 1'b1;
                    end else begin
                        d.st  = SQ_LOW;
                        d.cnt = q.cnt + 1'b1;
                        d.sh  = q.sh << 1;
                    end
                end
            end
            SQ_HOLD:  if (pend_i) d.st = SQ_IDLE;
            default:  d.st = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st  <= SQ_IDLE;
            q.sh  <= '0;
            q.cnt <= '0;
        end else begin
            q <= d;
        end
    end

    assign run_o      = (q.st == SQ_SETUP) || (q.st == SQ_START) ||
                        (q.st == SQ_LOW)   || (q.st == SQ_HIGH);
    assign idle_o     = (q.st == SQ_IDLE);
    assign done_o     = done;
    assign ack_line_o = sda_s_i;
    assign scl_oe_o   = (q.st == SQ_LOW) || (q.st == SQ_HOLD);
    assign sda_oe_o   = (q.st == SQ_START) ||
                        (((q.st == SQ_LOW) || (q.st == SQ_HIGH)) &&
                         (q.cnt != LAST) && !q.sh[BYTE_W-1]);

    AST_SDA_FREE_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == SQ_HIGH && q.cnt == LAST) |-> !sda_oe_o); // R5
    AST_HOLD_KEEPS_SCL: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == SQ_HOLD && !pend_i) |=> scl_oe_o); // R7
    AST_NINE_PULSES: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == SQ_HIGH) |-> q.cnt <= LAST); // R4

endmodule

// File: rtl/i2c_addr_master.sv
module i2c_addr_master
    import i2c_am_pkg::*;
#(
    parameter int DIV_W       = 8,
    parameter int DIV_RST     = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_we,
    input  logic [1:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       irq_o,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       scl_oe_o,
    output logic       sda_oe_o
);

    localparam int BYTE_W = 8;

    typedef struct packed {
        logic [BYTE_W-1:0] adr_buf;
        logic [DIV_W-1:0]  div;
        logic              mst;
        logic              tx;
        logic              pend;
        logic              lrb;
    } rg_t;

    rg_t  q, d;
    logic go, seq_run, seq_idle, seq_done, ack_line, tick, sda_s, bus_busy;

    i2c_am_linemon #(.SYNC_STAGES(SYNC_STAGES)) u_mon (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_i   (scl_i),
        .sda_i   (sda_i),
        .sda_s_o (sda_s),
        .busy_o  (bus_busy)
    );

    i2c_am_halfclk #(.DIV_W(DIV_W)) u_half (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (seq_run),
        .div_i  (q.div),
        .tick_o (tick)
    );

    i2c_am_seq #(.BYTE_W(BYTE_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .go_i       (go),
        .byte_i     (q.adr_buf),
        .pend_i     (q.pend),
        .tick_i     (tick),
        .sda_s_i    (sda_s),
        .run_o      (seq_run),
        .idle_o     (seq_idle),
        .done_o     (seq_done),
        .ack_line_o (ack_line),
        .scl_oe_o   (scl_oe_o),
        .sda_oe_o   (sda_oe_o)
    );

    always_comb begin
        d  = q;
        go = 1'b0;
        if (seq_done) begin
            d.pend = 1'b0;
            d.lrb  = ack_line;
            if (!ack_line) begin
                d.tx = ~q.adr_buf[0];
            end
        end
        if (reg_we) begin
            case (reg_addr)
                RA_BUF: if (seq_idle) d.adr_buf = reg_wdata;
                RA_CTL: begin
                    if (reg_wdata[7:4] == START_CODE) begin
                        if (seq_idle && !bus_busy) begin
                            go     = 1'b1;
                            d.mst  = 1'b1;
                            d.tx   = 1'b1;
                            d.pend = 1'b1;
                        end
                    end else begin
                        if (seq_idle) begin
                            d.mst = reg_wdata[CTL_MST];
                            d.tx  = reg_wdata[CTL_TX];
                        end
                        if (reg_wdata[CTL_PEND] && !seq_done) begin
                            d.pend = 1'b1;
                        end
                    end
                end
                RA_DIV: if (seq_idle) d.div = reg_wdata[DIV_W-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.adr_buf <= '0;
            q.div     <= DIV_W'(DIV_RST);
            q.mst     <= 1'b0;
            q.tx      <= 1'b0;
            q.pend    <= 1'b1;
            q.lrb     <= 1'b0;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            RA_BUF: reg_rdata = q.adr_buf;
            RA_CTL: begin
                reg_rdata[CTL_MST]  = q.mst;
                reg_rdata[CTL_TX]   = q.tx;
                reg_rdata[CTL_BSY]  = bus_busy;
                reg_rdata[CTL_PEND] = q.pend;
            end
            RA_STAT: begin
                reg_rdata[STAT_BSY] = bus_busy;
                reg_rdata[STAT_LRB] = q.lrb;
            end
            default: reg_rdata[DIV_W-1:0] = q.div;
        endcase
    end

    assign irq_o = q.mst && !q.pend;

    AST_PEND_DROP_ON_NINTH: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done |=> (!q.pend && irq_o)); // R6
    AST_TX_KEPT_ON_NACK: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_done && ack_line) |=> (q.tx == $past(q.tx))); // R8
    AST_NO_START_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_idle && bus_busy) |=> !seq_run); // R2
    AST_SCL_LOW_WHILE_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (q.mst && !q.pend) |-> scl_oe_o); // R7

endmodule

// File: tb/i2c_addr_master_tb.sv
module i2c_addr_master_tb;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       reg_we;
    logic [1:0] reg_addr;
    logic [7:0] reg_wdata;
    wire  [7:0] reg_rdata;
    wire        irq;
    wire        scl_oe, sda_oe;
    logic       tb_sda_ack, tb_sda_force;

    always #10 clk = ~clk;

    wire scl_line = ~scl_oe;
    wire sda_line = ~(sda_oe | tb_sda_ack | tb_sda_force);

    i2c_addr_master u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq_o     (irq),
        .scl_i     (scl_line),
        .sda_i     (sda_line),
        .scl_oe_o  (scl_oe),
        .sda_oe_o  (sda_oe)
    );

    int n_checks = 0;
    int n_fail   = 0;

    logic       prev_scl, prev_sda, ninth_oe, counting, ack_en;
    logic [7:0] cap;
    int         rises, falls, hcnt, hw, dcnt, dly;

    // Bus monitor and slave model, sampled away from the active edge
    always @(negedge clk) begin
        logic st_seen;
        st_seen = 1'b0;
        if (rst_n) begin
            if (prev_sda && !sda_line && scl_line && prev_scl) begin
                counting = 1'b1;
                dcnt     = 1;
                st_seen  = 1'b1;
            end
            if (scl_line && !prev_scl) begin
                rises = rises + 1;
                if (rises <= 8) cap = {cap[6:0], sda_line};
                if (rises == 9) ninth_oe = sda_oe;
                hcnt = 1;
            end else if (scl_line) begin
                hcnt = hcnt + 1;
                if (counting && !st_seen) dcnt = dcnt + 1;
            end else if (prev_scl) begin
                falls = falls + 1;
                hw    = hcnt;
                if (counting) begin
                    dly      = dcnt;
                    counting = 1'b0;
                end
                if (rises == 8) tb_sda_ack = ack_en;
                if (rises == 9) tb_sda_ack = 1'b0;
            end
        end
        prev_scl = scl_line;
        prev_sda = sda_line;
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] v);
        @(posedge clk); #2;
        reg_addr = a; reg_wdata = v; reg_we = 1'b1;
        @(posedge clk); #2;
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        @(posedge clk); #2;
        reg_addr = a;
        #3 v = reg_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_mon();
        rises = 0; falls = 0; cap = '0; ninth_oe = 1'b1;
        dly = -1; hw = -1; counting = 1'b0;
    endtask

    task automatic bus_stop();
        tb_sda_force = 1'b1; idle(8);
        tb_sda_force = 1'b0; idle(8);
    endtask

    task automatic xfer(input logic [7:0] b, input logic ack, input int div);
        logic [7:0] v;
        logic       txe;
        int         t;
        clear_mon();
        ack_en = ack;
        wr(2'd0, b);
        wr(2'd1, 8'hF8);
        t = 0;
        while (!irq && t < 2000) begin @(negedge clk); t++; end
        chk("R6 irq after ninth clock", irq, 1);
        chk("R4 scl pulse count", rises, 9);
        chk("R4 shifted byte", cap, b);
        chk("R5 sda pull-down on ninth clock", ninth_oe, 0);
        chk("R9 sda fall to first scl fall", dly, div + 1);
        chk("R9 scl high width", hw, div + 1);
        txe = ack ? ~b[0] : 1'b1;
        rd(2'd1, v);
        chk("R8 R6 R10 control after address", v, {1'b1, txe, 1'b1, 1'b0, 4'h0});
        rd(2'd2, v);
        chk("R8 status last bit", v, {2'b00, 1'b1, 4'h0, ~ack});
        idle(20);
        chk("R7 scl held low", scl_line, 0);
        chk("R7 no extra pulse", rises, 9);
        wr(2'd1, 8'h10);
        idle(4);
        chk("R7 scl released", scl_line, 1);
        chk("R7 irq dropped", irq, 0);
        bus_stop();
        rd(2'd2, v);
        chk("R10 stop frees bus", v, {7'h00, ~ack});
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL R4 watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] v;
        rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
        tb_sda_ack = 1'b0; tb_sda_force = 1'b0; ack_en = 1'b0;
        prev_scl = 1'b1; prev_sda = 1'b1;
        clear_mon();
        hcnt = 0; dcnt = 0;
        idle(3);
        rst_n = 1'b1;
        idle(4);

        rd(2'd1, v); chk("R1 control reset", v, 8'h10);
        rd(2'd2, v); chk("R1 status reset", v, 8'h00);
        rd(2'd3, v); chk("R1 divider reset", v, 8'd3);
        chk("R1 irq reset", irq, 0);
        chk("R1 lines released", {scl_line, sda_line}, 2'b11);

        wr(2'd0, 8'hA5);
        rd(2'd0, v); chk("R3 buffer readback", v, 8'hA5);

        wr(2'd1, 8'h00);
        rd(2'd1, v); chk("R11 pending not cleared by zero", v, 8'h10);
        wr(2'd1, 8'hC0);
        rd(2'd1, v); chk("R11 master and transmit loaded", v, 8'hD0);
        chk("R11 no irq with pending set", irq, 0);
        wr(2'd1, 8'h40);
        rd(2'd1, v); chk("R11 master cleared", v, 8'h50);
        wr(2'd1, 8'h00);

        // foreign master takes the bus
        clear_mon();
        tb_sda_force = 1'b1;
        idle(6);
        rd(2'd2, v); chk("R10 foreign start sets busy", v, 8'h20);
        wr(2'd1, 8'hF8);
        idle(60);
        chk("R2 no scl activity when busy", falls, 0);
        rd(2'd1, v); chk("R2 control unchanged", v, 8'h30);
        tb_sda_force = 1'b0;
        idle(8);
        rd(2'd2, v); chk("R10 foreign stop clears busy", v, 8'h00);

        for (int b = 0; b < 256; b++) begin
            xfer(8'(b), (b % 5) != 0, 3);
        end

        wr(2'd3, 8'd2);
        rd(2'd3, v); chk("R9 divider written", v, 8'd2);
        xfer(8'h5A, 1'b1, 2);
        xfer(8'hA5, 1'b1, 2);
        wr(2'd3, 8'd7);
        xfer(8'h81, 1'b0, 7);
        xfer(8'h81, 1'b1, 7);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule